// File: doc/BRIEF.md
# Debug Port Switch Sequence Generator

This block sits on the host side of a debug adapter. It drives the test clock and the shared mode/data line of a target so that the target's debug port moves between JTAG and serial-wire operation. One request on `startReq` produces a whole preamble, in three phases: a run of logic-one bits, a 16-bit switch code sent least significant bit first, and a second run of ones. The second run leaves a target that was already in serial-wire mode in its line-reset state. The `toJtag` input picks which code is sent. The `recovery` input drops the trailing run, which is what the recovery flow of a locked target needs.

The debug clock is made from the system clock. Each half period lasts `clkDiv + 1` system clocks, and the low half comes first. The data line changes only when the debug clock falls, so it holds steady around the rising edge at which the target samples it. `busy` covers the whole sequence. `done` pulses once when the sequence ends, and after that the clock line rests low and the data line rests high.

Top module: `swj_switch_gen`

## Requirements
- R1: After reset, and whenever reset is applied during a sequence, `tckOut`=0, `tmsOut`=1, `busy`=0 and `done`=0.
- R2: Phase one is a run of rising clock edges with `tmsOut`=1. Its length is the run length latched when the start is accepted.
- R3: With `toJtag`=0, phase two presents the 16 bits of 0xE79E at 16 consecutive rising edges, bit 0 first.
- R4: With `toJtag`=1, phase two presents the 16 bits of 0xE73C at 16 consecutive rising edges, bit 0 first.
- R5: With `recovery`=0, phase three presents `tmsOut`=1 for the same run length as phase one, and then the sequence ends.
- R6: With `recovery`=1, the sequence ends right after the last code bit, so the total is run length + 16 rising edges.
- R7: Each low half and each high half of `tckOut` lasts `clkDiv`+1 system clocks, starting with the low half. `tckOut` never rises while `busy`=0 and rests low when idle.
- R8: `tmsOut` changes only in the system-clock cycle in which `tckOut` falls.
- R9: `busy` rises in the cycle after the accepted start and stays high for exactly bits×2×(`clkDiv`+1) system clocks. `done` is high for exactly one clock, the first clock after `busy` falls.
- R10: A start request while `busy`=1 is ignored. Direction, recovery and length changes made then do not affect the running sequence, and no second sequence follows it.
- R11: The run length is `onesCount` when that value is 50 or more, and 50 when it is below 50. The 6-bit field caps it at 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Start request, accepted only while idle |
| toJtag | input | 1 | 0: switch to serial-wire (0xE79E); 1: switch to JTAG (0xE73C) |
| recovery | input | 1 | 1: omit the trailing run of ones |
| onesCount | input | CNT_W (6) | Requested length of each run of ones |
| clkDiv | input | DIV_W (8) | Half period of the debug clock, minus one, in system clocks |
| tckOut | output | 1 | Generated debug clock |
| tmsOut | output | 1 | Mode/data line |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-clock end-of-sequence pulse |

## Verification
The bench uses the default parameters: a 6-bit run-length field with a floor of 50, a 16-bit code and an 8-bit divider. It sets the divider to 0 through 3, which keeps sequences of up to 142 bits short. It still shows the difference between one-clock and multi-clock half periods. Run lengths of 0, 10, 49, 50, 55 and 63 cover the clamp and both ends of the field. Combining both directions with recovery on and off reaches every phase transition, and a start request held high partway through a sequence, with the other direction, exercises the ignore rule.

// File: rtl/swj_pkg.sv
package swj_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LEAD,
    ST_CODE,
    ST_TRAIL
  } seqState_t;

  // Strobes from the control to the datapath, valid for one system clock
  typedef struct packed {
    logic load;        // accept start: latch code, first bit is a one
    logic advance;     // bit boundary: present the next bit
    logic nextIsCode;  // with advance: next bit comes from the code shifter
    logic finish;      // last bit ended: return lines to idle
  } seqStrobes_t;

endpackage

// File: rtl/swj_control.sv
module swj_control
  import swj_pkg::*;
#(
  parameter int CNT_W    = 6,
  parameter int MIN_ONES = 50,
  parameter int CODE_W   = 16,
  parameter logic [CODE_W-1:0] CODE_TO_SW   = 16'hE79E,
  parameter logic [CODE_W-1:0] CODE_TO_JTAG = 16'hE73C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              toJtag,
  input  logic              recovery,
  input  logic [CNT_W-1:0]  onesCount,
  input  logic              bitEnd,
  output seqStrobes_t       strb,
  output logic [CODE_W-1:0] codeWord,
  output logic              busy,
  output logic              done
);

  localparam int CODE_CW = $clog2(CODE_W);
  localparam int BC_W    = (CODE_CW > CNT_W) ? CODE_CW : CNT_W;
  localparam logic [CNT_W-1:0] MIN_LEN   = CNT_W'(MIN_ONES);
  localparam logic [BC_W-1:0]  CODE_LAST = BC_W'(CODE_W - 1);

  seqState_t        state, stateNext;
  logic [BC_W-1:0]  bitCnt, bitCntNext;
  logic [CNT_W-1:0] leadLen;
  logic [CNT_W-1:0] leadEff;
  logic             recLatched;
  logic             accept;

  assign leadEff  = (onesCount < MIN_LEN) ? MIN_LEN : onesCount;
  assign codeWord = toJtag ? CODE_TO_JTAG : CODE_TO_SW;
  assign busy     = (state != ST_IDLE);
  assign accept   = (state == ST_IDLE) && startReq;

  always_comb begin
    stateNext  = state;
    bitCntNext = bitCnt;
    strb       = '0;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          strb.load  = 1'b1;
          stateNext  = ST_LEAD;
          bitCntNext = BC_W'(leadEff) - 1'b1;
        end
      end
      ST_LEAD: begin
        if (bitEnd) begin
          strb.advance = 1'b1;
          if (bitCnt == '0) begin
            strb.nextIsCode = 1'b1;
            stateNext       = ST_CODE;
            bitCntNext      = CODE_LAST;
          end else begin
            bitCntNext = bitCnt - 1'b1;
          end
        end
      end
      ST_CODE: begin
        if (bitEnd) begin
          if (bitCnt == '0) begin
            if (recLatched) begin
              strb.finish = 1'b1;
              stateNext   = ST_IDLE;
            end else begin
              strb.advance = 1'b1;
              stateNext    = ST_TRAIL;
              bitCntNext   = BC_W'(leadLen) - 1'b1;
            end
          end else begin
            strb.advance    = 1'b1;
            strb.nextIsCode = 1'b1;
            bitCntNext      = bitCnt - 1'b1;
          end
        end
      end
      ST_TRAIL: begin
        if (bitEnd) begin
          if (bitCnt == '0) begin
            strb.finish = 1'b1;
            stateNext   = ST_IDLE;
          end else begin
            strb.advance = 1'b1;
            bitCntNext   = bitCnt - 1'b1;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      bitCnt     <= '0;
      leadLen    <= MIN_LEN;
      recLatched <= 1'b0;
      done       <= 1'b0;
    end else begin
      state  <= stateNext;
      bitCnt <= bitCntNext;
      done   <= strb.finish;
      if (accept) begin
        leadLen    <= leadEff;
        recLatched <= recovery;
      end
    end
  end

endmodule

// File: rtl/swj_datapath.sv
module swj_datapath
  import swj_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int CODE_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strb,
  input  logic [CODE_W-1:0] codeWord,
  input  logic [DIV_W-1:0]  clkDiv,
  input  logic              active,
  output logic              tckOut,
  output logic              tmsOut,
  output logic              bitEnd
);

  logic [DIV_W-1:0]  halfCnt;
  logic [CODE_W-1:0] codeShift;
  logic              halfDone;

  assign halfDone = active && (halfCnt == clkDiv);
  assign bitEnd   = halfDone && tckOut;

  // Half-period timer of the generated clock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      halfCnt <= '0;
    end else if (!active || strb.load || halfDone) begin
      halfCnt <= '0;
    end else begin
      halfCnt <= halfCnt + 1'b1;
    end
  end

  // Generated clock: rises mid-bit, falls at every bit boundary
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tckOut <= 1'b0;
    end else if (strb.load || strb.advance || strb.finish) begin
      tckOut <= 1'b0;
    end else if (halfDone && !tckOut) begin
      tckOut <= 1'b1;
    end
  end

  // Code serialiser and data line, updated only at falling edges
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeShift <= '0;
      tmsOut    <= 1'b1;
    end else if (strb.load) begin
      codeShift <= codeWord;
      tmsOut    <= 1'b1;
    end else if (strb.advance) begin
      if (strb.nextIsCode) begin
        tmsOut    <= codeShift[0];
        codeShift <= codeShift >> 1;
      end else begin
        tmsOut <= 1'b1;
      end
    end else if (strb.finish) begin
      tmsOut <= 1'b1;
    end
  end

endmodule

// File: rtl/swj_switch_gen.sv
module swj_switch_gen
  import swj_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int CNT_W    = 6,
  parameter int MIN_ONES = 50,
  parameter int CODE_W   = 16,
  parameter logic [CODE_W-1:0] CODE_TO_SW   = 16'hE79E,
  parameter logic [CODE_W-1:0] CODE_TO_JTAG = 16'hE73C
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             toJtag,
  input  logic             recovery,
  input  logic [CNT_W-1:0] onesCount,
  input  logic [DIV_W-1:0] clkDiv,
  output logic             tckOut,
  output logic             tmsOut,
  output logic             busy,
  output logic             done
);

  seqStrobes_t       strb;
  logic [CODE_W-1:0] codeWord;
  logic              bitEnd;

  swj_control #(
    .CNT_W(CNT_W), .MIN_ONES(MIN_ONES), .CODE_W(CODE_W),
    .CODE_TO_SW(CODE_TO_SW), .CODE_TO_JTAG(CODE_TO_JTAG)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .toJtag(toJtag),
    .recovery(recovery), .onesCount(onesCount), .bitEnd(bitEnd),
    .strb(strb), .codeWord(codeWord), .busy(busy), .done(done)
  );

  swj_datapath #(
    .DIV_W(DIV_W), .CODE_W(CODE_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .codeWord(codeWord),
    .clkDiv(clkDiv), .active(busy), .tckOut(tckOut), .tmsOut(tmsOut),
    .bitEnd(bitEnd)
  );

endmodule

// File: rtl/swj_switch_checker.sv
module swj_switch_checker (
  input logic clk,
  input logic rstN,
  input logic tckOut,
  input logic tmsOut,
  input logic busy,
  input logic done
);

  // R8: data line moves only together with a falling clock
  a_r8_tms_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(tmsOut) |-> $fell(tckOut));

  // R7: the clock never rises outside a sequence
  a_r7_rise_needs_busy: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tckOut) |-> busy);

  // R7: clock rests low when idle
  a_r7_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !tckOut);

  // R9: done appears only in the first cycle after busy drops
  a_r9_done_after_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(busy) && !busy));

  // R9: done lasts a single clock
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

bind swj_switch_gen swj_switch_checker u_chk (
  .clk(clk), .rstN(rstN), .tckOut(tckOut), .tmsOut(tmsOut),
  .busy(busy), .done(done)
);

// File: tb/tb_swj_switch_gen.sv
module tb_swj_switch_gen;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startReq = 1'b0;
  logic       toJtag = 1'b0;
  logic       recovery = 1'b0;
  logic [5:0] onesCount = 6'd50;
  logic [7:0] clkDiv = 8'd0;
  logic       tckOut, tmsOut, busy, done;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  swj_switch_gen dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .toJtag(toJtag),
    .recovery(recovery), .onesCount(onesCount), .clkDiv(clkDiv),
    .tckOut(tckOut), .tmsOut(tmsOut), .busy(busy), .done(done)
  );

  // {dir, rec, poke, ones[5:0], div[7:0], expectedBits[7:0]}
  localparam int NV = 6;
  localparam logic [24:0] VECS [NV] = '{
    {1'b0, 1'b0, 1'b0, 6'd50, 8'd0, 8'd116},
    {1'b1, 1'b0, 1'b0, 6'd63, 8'd1, 8'd142},
    {1'b0, 1'b1, 1'b0, 6'd55, 8'd2, 8'd71},
    {1'b1, 1'b1, 1'b0, 6'd10, 8'd0, 8'd66},
    {1'b0, 1'b0, 1'b1, 6'd0,  8'd3, 8'd116},
    {1'b1, 1'b0, 1'b0, 6'd49, 8'd0, 8'd116}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic runSeq(input logic dir, input logic rec, input logic poke,
                        input logic [5:0] ones, input logic [7:0] div,
                        input int expBits);
    int    nLead;
    int    nExp;
    int    nGot;
    int    busyCyc;
    int    runLen;
    int    halfErr;
    int    leadErr;
    int    codeErr;
    int    trailErr;
    logic  prevTck;
    logic [15:0] code;
    logic  gotBits [0:199];
    nLead = (ones < 6'd50) ? 50 : int'(ones);            // R11 clamp
    nExp  = nLead + 16 + (rec ? 0 : nLead);
    code  = dir ? 16'hE73C : 16'hE79E;
    check(nExp == expBits, "R6", "table bit count", nExp, expBits);

    @(negedge clk);
    toJtag = dir; recovery = rec; onesCount = ones; clkDiv = div;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    check(busy == 1'b1, "R9", "busy after start", int'(busy), 1);

    nGot = 0; busyCyc = 1; runLen = 1; halfErr = 0; prevTck = tckOut;
    while (busy) begin
      if (poke && nGot == 20) begin
        startReq = 1'b1; toJtag = ~dir; recovery = ~rec; onesCount = 6'd63;
      end
      if (poke && nGot == 25) begin
        startReq = 1'b0; toJtag = dir; recovery = rec; onesCount = ones;
      end
      @(negedge clk);
      if (tckOut != prevTck) begin
        if (runLen != int'(div) + 1) halfErr++;
        runLen = 1;
        if (tckOut && nGot < 200) begin
          gotBits[nGot] = tmsOut;
          nGot++;
        end
      end else begin
        runLen++;
      end
      prevTck = tckOut;
      if (busy) busyCyc++;
    end
    startReq = 1'b0;

    check(done == 1'b1, "R9", "done after busy falls", int'(done), 1);
    check(tckOut == 1'b0 && tmsOut == 1'b1, "R7", "idle lines at end",
          int'({tckOut, tmsOut}), 1);
    check(nGot == nExp, rec ? "R6" : "R5", "rising edge count", nGot, nExp);
    check(busyCyc == nExp * 2 * (int'(div) + 1), "R9", "busy length",
          busyCyc, nExp * 2 * (int'(div) + 1));
    check(halfErr == 0, "R7", "half period errors", halfErr, 0);

    leadErr = 0; codeErr = 0; trailErr = 0;
    for (int i = 0; i < nGot && i < nExp; i++) begin
      if (i < nLead) begin
        if (gotBits[i] !== 1'b1) leadErr++;
      end else if (i < nLead + 16) begin
        if (gotBits[i] !== code[i - nLead]) codeErr++;
      end else begin
        if (gotBits[i] !== 1'b1) trailErr++;
      end
    end
    check(leadErr == 0, (ones < 6'd50) ? "R11" : "R2", "lead bit errors",
          leadErr, 0);
    check(codeErr == 0, dir ? "R4" : "R3", "code bit errors", codeErr, 0);
    if (!rec) check(trailErr == 0, "R5", "trail bit errors", trailErr, 0);

    @(negedge clk);
    check(done == 1'b0, "R9", "done single pulse", int'(done), 0);
    check(busy == 1'b0, "R10", "no second sequence", int'(busy), 0);
    repeat (3) @(negedge clk);
    if (poke) check(busy == 1'b0 && tckOut == 1'b0, "R10",
                    "held start ignored", int'({busy, tckOut}), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    check(tckOut == 1'b0 && tmsOut == 1'b1 && busy == 1'b0 && done == 1'b0,
          "R1", "reset state", int'({tckOut, tmsOut, busy, done}), 4);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(busy == 1'b0 && tckOut == 1'b0, "R7", "idle before start",
          int'({busy, tckOut}), 0);

    for (int v = 0; v < NV; v++) begin
      runSeq(VECS[v][24], VECS[v][23], VECS[v][22], VECS[v][21:16],
             VECS[v][15:8], int'(VECS[v][7:0]));
    end

    // R1: reset in the middle of a sequence
    @(negedge clk);
    toJtag = 1'b0; recovery = 1'b0; onesCount = 6'd50; clkDiv = 8'd0;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    repeat (40) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(tckOut == 1'b0 && tmsOut == 1'b1 && busy == 1'b0 && done == 1'b0,
          "R1", "reset mid-sequence", int'({tckOut, tmsOut, busy, done}), 4);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // Recovery after mid-sequence reset: full sequence still correct
    runSeq(1'b0, 1'b1, 1'b0, 6'd50, 8'd1, 66);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule